// File: doc/BRIEF.md
# Configurable RAM Window Decoder

This block is the address-decode stage in front of a DRAM controller. The CPU sees an 8 MB RAM window. A 3-bit map field inside a 32-bit control word decides how the window is split. Each 1 MB segment of the window is one of three kinds: real RAM, a floating (open-bus) area, or an invalid area. Every CPU access is classified against the map. A RAM hit is passed on to the DRAM side with a physical address. A floating hit returns all-ones data and drops any write. An invalid hit raises a bus error.

A static strap input states how much DRAM is fitted, either 2 MB or 8 MB. When only 2 MB is fitted, every RAM hit is folded modulo 2 MB, so the small device repeats across the window. The decision is registered: the outcome of an access and the DRAM request appear one clock after the access is presented. DRAM timing is handled downstream and is not part of this block.

Top module: `ram_window_decoder`

## Requirements
- R1: After reset the control word reads 0x0000_0A00, which puts map field 101 (full 8 MB) in bits [11:9]. No outcome output (ram_en, bus_err, open_bus) is asserted until an access is made.
- R2: When reg_we is high at a clock edge, the whole 32-bit reg_wdata is stored. reg_rdata shows exactly that word from the next cycle on. The map field is bits [11:9] of the word.
- R3: An access into a RAM segment raises ram_en one cycle later, with bus_err and open_bus low. ram_we equals the access's write flag and ram_wdata carries the access's data.
- R4: An access into an invalid segment raises bus_err one cycle later. ram_en, ram_we and open_bus stay low.
- R5: An access into a floating segment raises open_bus one cycle later with cpu_rdata all ones. ram_en, ram_we and bus_err stay low, so a write has no effect.
- R6: With segment s = address bits [22:20], the map field sets how many segments are RAM (V) and how many floating segments follow them (H). All remaining segments are invalid. The values are: 000 V=1 H=0; 001 V=4 H=0; 010 V=1 H=1; 011 V=4 H=4; 100 V=2 H=0; 101 V=8; 110 V=2 H=2; 111 V=8.
- R7: When ram_big is 0 (2 MB fitted), ram_addr = access address mod 2 MB. When ram_big is 1 (8 MB fitted), ram_addr equals the access address.
- R8: During a RAM response, cpu_rdata equals ram_rdata.
- R9: Exactly one of ram_en, bus_err and open_bus is high in the cycle after an access. All three are low in the cycle after a cycle with no access.
- R10: If an access and a register write arrive in the same cycle, the access is decoded with the map held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Current control word |
| ram_big | input | 1 | Static strap: 1 = 8 MB fitted, 0 = 2 MB fitted |
| acc_valid | input | 1 | CPU access present this cycle |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 23 | Byte address inside the window |
| acc_wdata | input | 32 | Write data of the access |
| ram_rdata | input | 32 | Read data returned by DRAM |
| ram_en | output | 1 | Access goes to real RAM |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 23 | Physical (folded) RAM address |
| ram_wdata | output | 32 | RAM write data |
| bus_err | output | 1 | Access hit an invalid segment |
| open_bus | output | 1 | Access hit a floating segment |
| cpu_rdata | output | 32 | Read data returned to the CPU |

## Verification
The assertions check the following on every cycle:
- at most one outcome flag is high, and no outcome follows an idle cycle;
- a write strobe reaches RAM only on a RAM hit of a write access;
- floating reads return all ones and RAM reads pass DRAM data through;
- the two full maps never fault;
- a 2 MB strap never produces an address above 2 MB;
- a written control word reads back unchanged.

Only the bench's scenarios can show the rest:
- the exact segment table of each of the eight map encodings, through a sweep of every map, segment, strap and direction;
- the folded address values;
- the old-map-wins ordering when a write and an access collide.

// File: rtl/ram_win_pkg.sv
package ram_win_pkg;

    // Outcome of one window access
    typedef enum logic [1:0] {
        OUT_NONE  = 2'd0,
        OUT_RAM   = 2'd1,
        OUT_FLOAT = 2'd2,
        OUT_FAULT = 2'd3
    } win_out_e;

    localparam int MAP_W = 3;

endpackage

// File: rtl/ram_win_map_decode.sv
module ram_win_map_decode
    import ram_win_pkg::*;
#(
    parameter int AW = 23
) (
    input  logic [MAP_W-1:0] map,
    input  logic [AW-1:0]    addr,
    output win_out_e         kind
);

    localparam int SEG_W = 3;

    logic [SEG_W+1:0] seg;
    logic [SEG_W+1:0] ram_units;
    logic [SEG_W+1:0] float_end;

    // Bits 2 and 0 of the map pick the size of the RAM part.
    // Bit 1 adds a floating part of the same size after it.
    always_comb begin
        seg = {2'b00, addr[AW-1 -: SEG_W]};
        unique case ({map[2], map[0]})
            2'b00:   ram_units = 5'd1;
            2'b01:   ram_units = 5'd4;
            2'b10:   ram_units = 5'd2;
            default: ram_units = 5'd8;
        endcase
        float_end = ram_units << 1;
        if (seg < ram_units) begin
            kind = OUT_RAM;
        end else if (map[1] && (seg < float_end)) begin
            kind = OUT_FLOAT;
        end else begin
            kind = OUT_FAULT;
        end
    end

endmodule

// File: rtl/ram_win_alias.sv
module ram_win_alias #(
    parameter int AW = 23
) (
    input  logic          ram_big,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] phys
);

    // The small device is a quarter of the window
    localparam int SMALL_AW = AW - 2;

    always_comb begin
        if (ram_big) begin
            phys = addr;
        end else begin
            phys = {2'b00, addr[SMALL_AW-1:0]};
        end
    end

endmodule

// File: rtl/ram_window_decoder.sv
module ram_window_decoder
    import ram_win_pkg::*;
#(
    parameter int          AW       = 23,
    parameter int          DW       = 32,
    parameter int          CW       = 32,
    parameter int          MAP_LSB  = 9,
    parameter logic [31:0] RST_CTRL = 32'h0000_0A00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [CW-1:0] reg_wdata,
    output logic [CW-1:0] reg_rdata,
    input  logic          ram_big,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    input  logic [DW-1:0] ram_rdata,
    output logic          ram_en,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    output logic          bus_err,
    output logic          open_bus,
    output logic [DW-1:0] cpu_rdata
);

    typedef struct packed {
        logic [CW-1:0] ctrl;
        win_out_e      kind;
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } state_t;

    state_t st_d, st_q;

    logic [MAP_W-1:0] map_q;
    win_out_e         dec_kind;
    logic [AW-1:0]    phys_addr;

    assign map_q = st_q.ctrl[MAP_LSB +: MAP_W];

    ram_win_map_decode #(.AW(AW)) u_map (
        .map  (map_q),
        .addr (acc_addr),
        .kind (dec_kind)
    );

    ram_win_alias #(.AW(AW)) u_alias (
        .ram_big (ram_big),
        .addr    (acc_addr),
        .phys    (phys_addr)
    );

    // Next-state: the access is decoded with the map held before any write this cycle
    always_comb begin
        st_d       = st_q;
        st_d.kind  = acc_valid ? dec_kind : OUT_NONE;
        st_d.wr    = acc_valid && acc_write && (dec_kind == OUT_RAM);
        st_d.addr  = phys_addr;
        st_d.wdata = acc_wdata;
        if (reg_we) begin
            st_d.ctrl = reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl  <= RST_CTRL[CW-1:0];
            st_q.kind  <= OUT_NONE;
            st_q.wr    <= 1'b0;
            st_q.addr  <= '0;
            st_q.wdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata = st_q.ctrl;
    assign ram_en    = (st_q.kind == OUT_RAM);
    assign ram_we    = ram_en && st_q.wr;
    assign ram_addr  = st_q.addr;
    assign ram_wdata = st_q.wdata;
    assign bus_err   = (st_q.kind == OUT_FAULT);
    assign open_bus  = (st_q.kind == OUT_FLOAT);
    assign cpu_rdata = open_bus ? {DW{1'b1}} : ram_rdata;

endmodule

// File: rtl/ram_window_decoder_chk.sv
module ram_window_decoder_chk #(
    parameter int AW      = 23,
    parameter int DW      = 32,
    parameter int CW      = 32,
    parameter int MAP_LSB = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [CW-1:0] reg_wdata,
    input logic [CW-1:0] reg_rdata,
    input logic          ram_big,
    input logic          acc_valid,
    input logic          acc_write,
    input logic [DW-1:0] ram_rdata,
    input logic          ram_en,
    input logic          ram_we,
    input logic [AW-1:0] ram_addr,
    input logic          bus_err,
    input logic          open_bus,
    input logic [DW-1:0] cpu_rdata
);

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ram_en, bus_err, open_bus}) <= 1); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc_valid) |-> !(ram_en || bus_err || open_bus)); // R9

    AST_WE_ONLY_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_en && $past(acc_write))); // R3

    AST_FAULT_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (!ram_we && $past(acc_valid))); // R4

    AST_FLOAT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        open_bus |-> (cpu_rdata == {DW{1'b1}} && !ram_we)); // R5

    AST_RAM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> (cpu_rdata == ram_rdata)); // R8

    AST_SMALL_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && !ram_big) |-> (ram_addr[AW-1:AW-2] == 2'b00)); // R7

    AST_FULL_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(acc_valid) && $past(reg_rdata[MAP_LSB]) && $past(reg_rdata[MAP_LSB+2]))
        |-> ram_en); // R6

    AST_REG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_we) |-> (reg_rdata == $past(reg_wdata))); // R2

endmodule

bind ram_window_decoder ram_window_decoder_chk #(
    .AW(AW), .DW(DW), .CW(CW), .MAP_LSB(MAP_LSB)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ram_big   (ram_big),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .ram_rdata (ram_rdata),
    .ram_en    (ram_en),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .bus_err   (bus_err),
    .open_bus  (open_bus),
    .cpu_rdata (cpu_rdata)
);

// File: tb/ram_window_decoder_bench.sv
`timescale 1ns/1ps
module ram_window_decoder_bench;

    localparam int UNIT = 1 << 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ram_big = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [22:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] ram_rdata;
    logic        ram_en, ram_we, bus_err, open_bus;
    logic [22:0] ram_addr;
    logic [31:0] ram_wdata;
    logic [31:0] cpu_rdata;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign ram_rdata = 32'hC0DE_0000 ^ {9'b0, ram_addr};

    ram_window_decoder u_ram_window_decoder (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ram_big(ram_big), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .ram_rdata(ram_rdata), .ram_en(ram_en), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .bus_err(bus_err),
        .open_bus(open_bus), .cpu_rdata(cpu_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Outcome from the map table: 1 RAM, 2 floating, 3 invalid
    function automatic int exp_kind(input int map, input int seg);
        int v, h;
        case (map)
            0: begin v = 1; h = 0; end
            1: begin v = 4; h = 0; end
            2: begin v = 1; h = 1; end
            3: begin v = 4; h = 4; end
            4: begin v = 2; h = 0; end
            6: begin v = 2; h = 2; end
            default: begin v = 8; h = 0; end
        endcase
        if (seg < v) return 1;
        if (seg < v + h) return 2;
        return 3;
    endfunction

    task automatic write_ctrl(input logic [31:0] w);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = w;
        @(negedge clk);
        reg_we = 1'b0;
        chk(reg_rdata == w, "R2 readback", reg_rdata, w);
    endtask

    task automatic access(input int map, input int seg, input int off_sel,
                          input bit wr, input bit big);
        logic [22:0] a;
        logic [22:0] phys;
        logic [3:0]  got, expv;
        int k;
        int offs;
        offs = (off_sel == 0) ? 0 : (off_sel == 1) ? UNIT - 1 : (UNIT / 2 + seg * 4099);
        a = 23'(seg * UNIT + offs);
        phys = big ? a : 23'(int'(a) % (2 * UNIT));
        k = exp_kind(map, seg);
        @(negedge clk);
        ram_big = big;
        acc_valid = 1'b1;
        acc_write = wr;
        acc_addr = a;
        acc_wdata = 32'h5500_0000 ^ {9'b0, a};
        @(negedge clk);
        acc_valid = 1'b0;
        acc_write = 1'b0;
        got = {ram_en, ram_we, bus_err, open_bus};
        expv = {k == 1, (k == 1) && wr, k == 3, k == 2};
        chk(got == expv, (k == 1) ? "R6 R3 ram outcome" :
                         (k == 2) ? "R6 R5 float outcome" : "R6 R4 fault outcome",
            {28'b0, got}, {28'b0, expv});
        if (k == 1) begin
            chk(ram_addr == phys, "R7 folded address", {9'b0, ram_addr}, {9'b0, phys});
            chk(cpu_rdata == (32'hC0DE_0000 ^ {9'b0, phys}), "R8 read data",
                cpu_rdata, 32'hC0DE_0000 ^ {9'b0, phys});
            if (wr) chk(ram_wdata == (32'h5500_0000 ^ {9'b0, a}), "R3 write data",
                        ram_wdata, 32'h5500_0000 ^ {9'b0, a});
        end
        if (k == 2) chk(cpu_rdata == 32'hFFFF_FFFF, "R5 float data", cpu_rdata, 32'hFFFF_FFFF);
        @(negedge clk);
        got = {ram_en, ram_we, bus_err, open_bus};
        chk(got == 4'b0, "R9 idle quiet", {28'b0, got}, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(reg_rdata == 32'h0000_0A00, "R1 reset ctrl", reg_rdata, 32'h0000_0A00);
        chk({ram_en, bus_err, open_bus} == 3'b0, "R1 reset outcomes",
            {29'b0, ram_en, bus_err, open_bus}, 32'h0);
        access(5, 7, 1, 1'b0, 1'b1);  // R1 full map active after reset

        // R6 sweep: every map, segment, strap, offset and direction
        for (int m = 0; m < 8; m++) begin
            write_ctrl((32'h5A5A_F1F1 & ~32'h0000_0E00) | (32'(m) << 9));
            for (int b = 0; b < 2; b++)
                for (int s = 0; s < 8; s++)
                    for (int o = 0; o < 3; o++)
                        for (int w = 0; w < 2; w++)
                            access(m, s, o, w[0], b[0]);
        end

        // R10 write and access in the same cycle: old map (000) decides
        write_ctrl(32'h0000_0000);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = 32'h0000_0A00;
        acc_valid = 1'b1;
        acc_write = 1'b0;
        acc_addr = 23'(3 * UNIT);
        ram_big = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        acc_valid = 1'b0;
        chk(bus_err == 1'b1 && ram_en == 1'b0, "R10 old map used",
            {30'b0, bus_err, ram_en}, 32'h2);
        chk(reg_rdata == 32'h0000_0A00, "R10 new map stored", reg_rdata, 32'h0000_0A00);
        access(5, 3, 0, 1'b0, 1'b1);  // R10 new map applies afterwards

        finish_run();
    end

endmodule